// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a watchdog for a system that keeps a free-running 64-bit time counter. Software programs a timeout offset and turns the block on. Turning it on arms a deadline equal to the current counter plus the offset. If the counter reaches the deadline before software sends a keepalive, the block raises a first-stage warning and arms a second deadline one offset later. If that deadline also passes without a keepalive, the block raises a second-stage signal. Downstream logic would normally route this signal to a reset source. A timeout that ignores the warning therefore lasts twice the offset.

Software reaches the block over a simple 32-bit register bus with two address regions, selected by a frame input. The control frame holds a control/status word, the offset as a low and a high word, the 64-bit deadline as two read-only words, and an identification word. Any write to the keepalive frame re-arms the block. A VERSION parameter sets the offset width. Version 0 has a 32-bit offset. Version 1 has a 48-bit offset, which lets a 1 GHz counter reach timeouts well beyond four seconds.

Top module: `wdog_two_stage`

## Requirements
- R1: After a synchronous reset, the block is disabled, both stage outputs are low, and the offset and deadline are zero. Every register word reads zero, except the identification word.
- R2: Control-frame word 0 reads {29'b0, stage1, stage0, enable}. Only bit 0 (enable) is writable. Bits 1 and 2 report the stage flags, and a write to them has no effect of its own.
- R3: A control write with bit 0 = 1 sets enable, sets the deadline to counter + offset, and clears both stage flags. A control write with bit 0 = 0 clears enable and both flags. While the block is disabled, neither stage output is ever high.
- R4: Any write to the keepalive frame (frame input = 1) sets the deadline to counter + offset and clears both flags. Every read from that frame returns zero.
- R5: In version 1, word 2 holds offset bits [31:0]. Word 3 holds offset bits [47:32] in its bits [15:0]. Bits [31:16] of word 3 always read zero, and writes to them are dropped. A write to either word re-arms the deadline with the new offset and clears both flags.
- R6: In version 0, the offset is 32 bits wide. Writes to word 3 do not change the offset, but they still re-arm the block. Word 3 always reads zero.
- R7: Word 15 reads the version in bits [19:16] and zero in all other bits. Any control-frame word without a defined meaning reads zero.
- R8: Words 4 and 5 read deadline bits [31:0] and [63:32].
- R9: At a clock edge where the block is enabled, no write is present, stage0 is clear and counter >= deadline (unsigned), stage0 is set and the deadline becomes counter + offset.
- R10: At such an edge with stage0 already set, stage1 is set. Stage1 only ever rises while stage0 is high, and it stays high until a re-arm or a disable.
- R11: Read data appears on the bus one clock after the read request and shows the state from before that edge. It is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = keepalive frame |
| bus_addr | input | ADDR_W | Word index within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_cnt | input | 64 | Free-running system counter |
| ws0_o | output | 1 | First-stage expiry flag |
| ws1_o | output | 1 | Second-stage expiry flag |

## Verification
The assertions assume at most one bus request per cycle, and they assume the counter never moves backwards past a deadline it has already crossed. The stimulus meets both conditions by construction. It drives one request per step and only ever adds a non-negative amount to the counter. That amount is usually small, with rare large jumps, and it starts far from wrap-around. Random offsets are mostly kept short so that both expiry stages occur often. Occasional large high-word offsets exercise the wide deadline arithmetic. Two instances share each stimulus, one per version, so the width-dependent behaviour is compared side by side.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 64;
    localparam int OFF_MAX = 48;

    localparam int W_CTRL   = 0;
    localparam int W_OFF_LO = 2;
    localparam int W_OFF_HI = 3;
    localparam int W_CMP_LO = 4;
    localparam int W_CMP_HI = 5;
    localparam int W_IDENT  = 15;

    typedef struct packed {
        logic              ctrl_wr;
        logic              off_lo_wr;
        logic              off_hi_wr;
        logic              kick;
        logic [DATA_W-1:0] wdata;
    } wr_strobe_t;

    typedef struct packed {
        logic en;
        logic ws0;
        logic ws1;
    } wd_flags_t;

    function automatic int off_width(input int ver);
        return (ver == 0) ? 32 : OFF_MAX;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input wd_flags_t f);
        return {{(DATA_W-3){1'b0}}, f.ws1, f.ws0, f.en};
    endfunction

endpackage

// File: rtl/wdog_bus_dec.sv
module wdog_bus_dec
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int VERSION = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic                 bus_frame,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  wd_flags_t            flags,
    input  logic [OFF_MAX-1:0]   off_q,
    input  logic [CNT_W-1:0]     wcv_q,
    output wr_strobe_t           strobe,
    output logic [DATA_W-1:0]    bus_rdata
);

    localparam logic [3:0] VER_FIELD = 4'(VERSION);

    logic [DATA_W-1:0] rd_mux;
    int                word;

    assign word = int'(bus_addr);

    always_comb begin
        strobe       = '0;
        strobe.wdata = bus_wdata;
        if (bus_en && bus_wr) begin
            if (bus_frame) begin
                strobe.kick = 1'b1;
            end else begin
                strobe.ctrl_wr   = (word == W_CTRL);
                strobe.off_lo_wr = (word == W_OFF_LO);
                strobe.off_hi_wr = (word == W_OFF_HI);
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (!bus_frame) begin
            case (word)
                W_CTRL:   rd_mux = ctrl_word(flags);
                W_OFF_LO: rd_mux = off_q[31:0];
                W_OFF_HI: rd_mux = {16'b0, off_q[OFF_MAX-1:32]};
                W_CMP_LO: rd_mux = wcv_q[31:0];
                W_CMP_HI: rd_mux = wcv_q[CNT_W-1:32];
                W_IDENT:  rd_mux = {12'b0, VER_FIELD, 16'b0};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_en && !bus_wr)
            bus_rdata <= rd_mux;
        else
            bus_rdata <= '0;
    end

    AST_KICK_FRAME_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_frame) |=> (bus_rdata == '0)); // R4
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_wr) |=> (bus_rdata == '0)); // R11

endmodule

// File: rtl/wdog_offset.sv
module wdog_offset
    import wdog_pkg::*;
#(
    parameter int VERSION = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_strobe_t         strobe,
    output logic [OFF_MAX-1:0] off_q,
    output logic [OFF_MAX-1:0] off_nxt
);

    localparam int OFF_W = off_width(VERSION);

    logic [31:0]         lo_q, lo_nxt;
    logic [OFF_MAX-33:0] hi_q, hi_nxt;

    assign lo_nxt = strobe.off_lo_wr ? strobe.wdata[31:0] : lo_q;

    generate
        if (OFF_W > 32) begin : g_wide
            assign hi_nxt = strobe.off_hi_wr ? strobe.wdata[OFF_MAX-33:0] : hi_q;
        end else begin : g_narrow
            assign hi_nxt = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end

    assign off_q   = {hi_q, lo_q};
    assign off_nxt = {hi_nxt, lo_nxt};

    AST_HI_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (strobe.off_hi_wr && !strobe.off_lo_wr) |=> (off_q[31:0] == $past(off_q[31:0]))); // R5
    AST_NARROW_HI_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (OFF_W == 32 && strobe.off_hi_wr) |=> $stable(off_q)); // R6

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_strobe_t         strobe,
    input  logic [OFF_MAX-1:0] off_q,
    input  logic [OFF_MAX-1:0] off_nxt,
    input  logic [CNT_W-1:0]   sys_cnt,
    output wd_flags_t          flags,
    output logic [CNT_W-1:0]   wcv_q
);

    localparam int PAD_W = CNT_W - OFF_MAX;

    logic rearm, turn_off, expired;

    assign turn_off = strobe.ctrl_wr && !strobe.wdata[0];
    assign rearm    = strobe.kick || strobe.off_lo_wr || strobe.off_hi_wr ||
                      (strobe.ctrl_wr && strobe.wdata[0]);
    assign expired  = flags.en && (sys_cnt >= wcv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            wcv_q <= '0;
        end else if (turn_off) begin
            flags <= '0;
        end else if (rearm) begin
            if (strobe.ctrl_wr)
                flags.en <= 1'b1;
            flags.ws0 <= 1'b0;
            flags.ws1 <= 1'b0;
            wcv_q     <= sys_cnt + {{PAD_W{1'b0}}, off_nxt};
        end else if (expired) begin
            if (!flags.ws0) begin
                flags.ws0 <= 1'b1;
                wcv_q     <= sys_cnt + {{PAD_W{1'b0}}, off_q};
            end else begin
                flags.ws1 <= 1'b1;
            end
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !flags.en |-> (!flags.ws0 && !flags.ws1)); // R3
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rearm || turn_off) |=> (!flags.ws0 && !flags.ws1)); // R4
    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        flags.ws1 |-> flags.ws0); // R10
    AST_WS1_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.ws1 && !rearm && !turn_off) |=> flags.ws1); // R10
    AST_WS0_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ws0) |-> $past(sys_cnt >= wcv_q)); // R9

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int VERSION = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       sys_cnt,
    output logic              ws0_o,
    output logic              ws1_o
);

    wr_strobe_t         strobe;
    wd_flags_t          flags;
    logic [OFF_MAX-1:0] off_q, off_nxt;
    logic [CNT_W-1:0]   wcv_q;

    wdog_bus_dec #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .off_q     (off_q),
        .wcv_q     (wcv_q),
        .strobe    (strobe),
        .bus_rdata (bus_rdata)
    );

    wdog_offset #(.VERSION(VERSION)) u_off (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .off_q   (off_q),
        .off_nxt (off_nxt)
    );

    wdog_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .off_q   (off_q),
        .off_nxt (off_nxt),
        .sys_cnt (sys_cnt),
        .flags   (flags),
        .wcv_q   (wcv_q)
    );

    assign ws0_o = flags.ws0;
    assign ws1_o = flags.ws1;

endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_wr = 1'b0, bus_frame = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [63:0] sys_cnt = '0;
    logic [31:0] rd_v1, rd_v0;
    logic        w0_v1, w1_v1, w0_v0, w1_v0;

    int checks = 0;
    int errors = 0;
    string tag_ovr = "";

    logic [63:0] m_wcv [2];
    logic [47:0] m_off [2];
    logic        m_en  [2];
    logic        m_ws0 [2];
    logic        m_ws1 [2];
    logic [31:0] exp_rd [2];
    logic        was_rd;
    logic [63:0] cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_two_stage #(.ADDR_W(4), .VERSION(1)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_frame(bus_frame),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_v1),
        .sys_cnt(sys_cnt), .ws0_o(w0_v1), .ws1_o(w1_v1));

    wdog_two_stage #(.ADDR_W(4), .VERSION(0)) u_dut_v0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_frame(bus_frame),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_v0),
        .sys_cnt(sys_cnt), .ws0_o(w0_v0), .ws1_o(w1_v0));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp,
                       input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mread(input int vi, input logic fr, input logic [3:0] ad);
        if (fr) return 32'h0;
        case (int'(ad))
            0:  return {29'b0, m_ws1[vi], m_ws0[vi], m_en[vi]};
            2:  return m_off[vi][31:0];
            3:  return {16'b0, m_off[vi][47:32]};
            4:  return m_wcv[vi][31:0];
            5:  return m_wcv[vi][63:32];
            15: return (vi == 1) ? 32'h0001_0000 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input int vi, input logic fr, input logic [3:0] ad);
        if (tag_ovr != "") return tag_ovr;
        if (fr) return "R4";
        case (int'(ad))
            0:       return "R2";
            2, 3:    return (vi == 0) ? "R6" : "R5";
            4, 5:    return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic model_update(input int vi, input logic en_i, input logic wr_i,
                                input logic fr_i, input logic [3:0] ad_i,
                                input logic [31:0] wd_i, input logic [63:0] c);
        logic [47:0] noff;
        logic        dis, rel, is_ctl;
        noff   = m_off[vi];
        dis    = 1'b0;
        rel    = 1'b0;
        is_ctl = 1'b0;
        if (en_i && wr_i) begin
            if (fr_i) rel = 1'b1;
            else begin
                case (int'(ad_i))
                    0: begin is_ctl = 1'b1; if (wd_i[0]) rel = 1'b1; else dis = 1'b1; end
                    2: begin noff[31:0] = wd_i; rel = 1'b1; end
                    3: begin if (vi == 1) noff[47:32] = wd_i[15:0]; rel = 1'b1; end
                    default: ;
                endcase
            end
        end
        m_off[vi] = noff;
        if (dis) begin
            m_en[vi] = 1'b0; m_ws0[vi] = 1'b0; m_ws1[vi] = 1'b0;
        end else if (rel) begin
            if (is_ctl) m_en[vi] = 1'b1;
            m_ws0[vi] = 1'b0; m_ws1[vi] = 1'b0;
            m_wcv[vi] = c + {16'b0, noff};
        end else if (m_en[vi] && c >= m_wcv[vi]) begin
            if (!m_ws0[vi]) begin
                m_ws0[vi] = 1'b1;
                m_wcv[vi] = c + {16'b0, noff};
            end else begin
                m_ws1[vi] = 1'b1;
            end
        end
    endtask

    task automatic step(input logic en_i, input logic wr_i, input logic fr_i,
                        input logic [3:0] ad_i, input logic [31:0] wd_i, input logic [63:0] c);
        @(negedge clk);
        bus_en = en_i; bus_wr = wr_i; bus_frame = fr_i; bus_addr = ad_i;
        bus_wdata = wd_i; sys_cnt = c;
        was_rd = en_i && !wr_i;
        for (int vi = 0; vi < 2; vi++) exp_rd[vi] = was_rd ? mread(vi, fr_i, ad_i) : 32'h0;
        @(posedge clk);
        for (int vi = 0; vi < 2; vi++) model_update(vi, en_i, wr_i, fr_i, ad_i, wd_i, c);
        #1;
        if (was_rd) begin
            chk(rd_tag(1, fr_i, ad_i), {32'h0, rd_v1}, {32'h0, exp_rd[1]}, "v1 read");
            chk(rd_tag(0, fr_i, ad_i), {32'h0, rd_v0}, {32'h0, exp_rd[0]}, "v0 read");
        end else begin
            chk("R11", {32'h0, rd_v1}, 64'h0, "rdata idle");
        end
        chk("R9",  {63'h0, w0_v1}, {63'h0, m_ws0[1]}, "v1 stage0");
        chk("R10", {63'h0, w1_v1}, {63'h0, m_ws1[1]}, "v1 stage1");
        chk("R9",  {63'h0, w0_v0}, {63'h0, m_ws0[0]}, "v0 stage0");
        chk("R10", {63'h0, w1_v0}, {63'h0, m_ws1[0]}, "v0 stage1");
        if (!m_en[1]) chk("R3", {62'h0, w1_v1, w0_v1}, 64'h0, "disabled quiet");
    endtask

    task automatic rd(input logic fr, input logic [3:0] ad);
        step(1'b1, 1'b0, fr, ad, 32'h0, cnt);
    endtask

    task automatic wr(input logic fr, input logic [3:0] ad, input logic [31:0] d);
        step(1'b1, 1'b1, fr, ad, d, cnt);
    endtask

    task automatic idle_adv(input int n, input int inc);
        for (int i = 0; i < n; i++) begin
            cnt = cnt + 64'(inc);
            step(1'b0, 1'b0, 1'b0, 4'h0, 32'h0, cnt);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0b1e));
        for (int vi = 0; vi < 2; vi++) begin
            m_wcv[vi] = '0; m_off[vi] = '0; m_en[vi] = 1'b0; m_ws0[vi] = 1'b0; m_ws1[vi] = 1'b0;
        end
        cnt = 64'd1000;
        sys_cnt = cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag_ovr = "R1";
        rd(1'b0, 4'd0); rd(1'b0, 4'd2); rd(1'b0, 4'd3); rd(1'b0, 4'd4); rd(1'b0, 4'd5);
        tag_ovr = "";
        rd(1'b0, 4'd15);                       // R7 identification
        rd(1'b0, 4'd9);                        // R7 undefined word

        // R5 / R6: offset layout and reserved bits
        wr(1'b0, 4'd2, 32'd100);
        wr(1'b0, 4'd3, 32'hABCD_0002);
        rd(1'b0, 4'd3); rd(1'b0, 4'd2);
        wr(1'b0, 4'd3, 32'h0);

        // R3 enable, R8 deadline
        wr(1'b0, 4'd0, 32'h1);
        rd(1'b0, 4'd0); rd(1'b0, 4'd4); rd(1'b0, 4'd5);

        // R9 / R10: two-stage expiry
        idle_adv(14, 10);
        idle_adv(12, 10);
        rd(1'b0, 4'd0);                        // R2 status shows both flags
        chk("R10", {62'h0, w1_v1, w0_v1}, 64'h3, "both stages after two offsets");

        // R4 keepalive frame
        wr(1'b1, 4'd7, 32'h0);
        rd(1'b1, 4'd0);
        chk("R4", {62'h0, w1_v1, w0_v1}, 64'h0, "keepalive clears");

        // R3 disable
        idle_adv(12, 10);
        wr(1'b0, 4'd0, 32'h6);
        idle_adv(30, 50);
        chk("R3", {62'h0, w1_v0, w0_v0}, 64'h0, "disabled stays low");

        // R5 wide offset deadline arithmetic
        wr(1'b0, 4'd2, 32'h0);
        wr(1'b0, 4'd3, 32'h1);
        wr(1'b0, 4'd0, 32'h1);
        rd(1'b0, 4'd5); rd(1'b0, 4'd4);
        idle_adv(5, 1000);

        // random phase
        wr(1'b0, 4'd2, 32'd60);
        wr(1'b0, 4'd3, 32'h0);
        wr(1'b0, 4'd0, 32'h1);
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [3:0] ad;
            cnt = cnt + 64'($urandom_range(0, 30));
            if ($urandom_range(0, 99) == 0) cnt = cnt + 64'($urandom_range(0, 100000));
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 6))
                0: ad = 4'd0; 1: ad = 4'd2; 2: ad = 4'd3; 3: ad = 4'd4;
                4: ad = 4'd5; 5: ad = 4'd15; default: ad = 4'($urandom_range(0, 15));
            endcase
            if (r < 60)       step(1'b0, 1'b0, 1'b0, 4'd0, 32'h0, cnt);
            else if (r < 75)  step(1'b1, 1'b0, 1'($urandom_range(0, 1)), ad, 32'h0, cnt);
            else if (r < 80)  step(1'b1, 1'b1, 1'b1, ad, $urandom, cnt);
            else if (r < 88)  step(1'b1, 1'b1, 1'b0, 4'd0,
                                   {$urandom_range(0, 65535), 15'h0,
                                    1'($urandom_range(0, 9) < 8)}, cnt);
            else if (r < 96)  step(1'b1, 1'b1, 1'b0, 4'd2, $urandom_range(0, 300), cnt);
            else              step(1'b1, 1'b1, 1'b0, 4'd3,
                                   {16'($urandom), 15'h0, 1'($urandom_range(0, 3) == 0)}, cnt);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule